// File: doc/BRIEF.md
# Stored-Stream Playback Address Sequencer

This block reads a byte-wide program memory in address order so that a stored stream can be played back. A synchronous binary counter does the stepping. Its lowest stage toggles every master clock and serves as the data-latch strobe. The stages above it drive the memory address, so each address stays on the bus for two clocks. The byte that the memory returns is captured in an output register once per address, and downstream logic takes it from there.

The stream ends with a marker byte, so the memory does not have to be filled. A byte is a command when its top bit is set. A command that also has its third-lowest bit set ends the data, for example 0x84. The marker is decoded from the captured byte and never from the live memory bus. When the captured byte is a marker, the counter returns to zero for exactly one master-clock cycle and then counts on. Address 0 then reloads the output register and clears the marker, and the sequencer cannot get stuck in reset. When no marker is ever stored, the address runs to its maximum and rolls over to zero.

Top module: `playback_seq`

## Requirements
- R1: The address output is 18 bits wide. It is made of the counter stages above the lowest stage. Each address value is held for exactly two master clocks, and then the address rises by one. All bits change on the same clock edge.
- R2: The strobe output is the lowest counter stage. It is 0 during the first clock of each address and 1 during the second.
- R3: The output register loads the memory data on the clock edge that ends a cycle with strobe 1. At every other edge it keeps its value.
- R4: A captured byte counts as an end marker only when both bit 7 and bit 2 are 1 (0x84, 0x8C and so on). A captured 0x80 or 0x04 does not disturb the count.
- R5: When an end marker is loaded into the output register, the next clock edge clears the counter. The address becomes 0 and the strobe becomes 0, and the output register still holds the marker. Counting resumes on the following edge, and the output register loads the byte at address 0 two edges after the clear.
- R6: An end-marker value on the live memory bus has no effect until it has been captured. While the marker's address is on the bus, the address keeps advancing normally.
- R7: The clear caused by an end marker never lasts more than one clock. This holds even when address 0 itself holds a marker, in which case the strobe keeps toggling.
- R8: While the synchronous active-high reset is sampled high, the counter and the output register are cleared to zero.
- R9: When no end marker is captured, the address rolls over from its all-ones value to 0 and keeps the normal two-clock rhythm. This is checked with a narrow address width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 18 | Address to the program memory |
| memData | input | 8 | Byte returned by the program memory |
| dataStrobe | output | 1 | Lowest counter stage; its high phase marks the capture cycle |
| latchData | output | 8 | Captured playback byte |

## Verification
A marker-free memory image shows the plain counting rhythm. Sampling it at early, middle and late points separates a wrong strobe phase from a wrong address step or a wrong capture point. Single command bytes that carry only bit 7 or only bit 2 show whether the marker decode requires both bits. A real marker mid-stream shows the one-cycle clear and the reload from address 0. While the marker's address is still on the bus, that same run shows that the live data is ignored. A marker at address 0 tests for lock-up. A narrow-width instance shows the natural rollover.

// File: rtl/playback_seq_pkg.sv
package playback_seq_pkg;

  // Strobes from the control to the datapath, valid for the current cycle.
  typedef struct packed {
    logic loadLatch;   // capture memory byte at this edge
    logic clearCount;  // force counter to zero at this edge
    logic advance;     // increment counter at this edge
  } seqStrobes_t;

endpackage

// File: rtl/playback_seq_ctrl.sv
module playback_seq_ctrl
  import playback_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CMD_BIT = 7,
  parameter int EOD_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phaseBit,
  input  logic [DATA_W-1:0] latchQ,
  output seqStrobes_t       strobes
);

  logic isMarker;
  logic justLoaded;

  // The decode looks only at the captured byte, never at the live bus.
  assign isMarker = latchQ[CMD_BIT] & latchQ[EOD_BIT];

  // justLoaded is high for the single cycle after a capture. Qualifying the
  // clear with it keeps the clear to one master clock.
  always_ff @(posedge clk) begin
    if (rst) justLoaded <= 1'b0;
    else     justLoaded <= strobes.loadLatch;
  end

  always_comb begin
    strobes.loadLatch  = phaseBit;
    strobes.clearCount = justLoaded & isMarker;
    strobes.advance    = ~strobes.clearCount;
  end

  // R7: a clear is never followed by another clear.
  p_clear_once_r7: assert property (@(posedge clk) disable iff (rst)
    strobes.clearCount |=> !strobes.clearCount);

  // R6: a clear only follows a capture in the previous cycle.
  p_clear_after_load_r6: assert property (@(posedge clk) disable iff (rst)
    strobes.clearCount |-> $past(strobes.loadLatch));

endmodule

// File: rtl/playback_seq_dp.sv
module playback_seq_dp
  import playback_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqStrobes_t       strobes,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              phaseBit,
  output logic [DATA_W-1:0] latchQ
);

  localparam int CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W:0]   carry;

  // Fully synchronous counter: each stage toggles on the ANDed carry, and
  // every stage is updated on the same edge.
  assign carry[0] = strobes.advance;

  generate
    for (genvar i = 0; i < CNT_W; i++) begin : g_stage
      assign cntNext[i]  = strobes.clearCount ? 1'b0 : (cnt[i] ^ carry[i]);
      assign carry[i+1]  = carry[i] & cnt[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cntNext;
  end

  always_ff @(posedge clk) begin
    if (rst)                    latchQ <= '0;
    else if (strobes.loadLatch) latchQ <= memData;
  end

  assign phaseBit = cnt[0];
  assign memAddr  = cnt[CNT_W-1:1];

  // R1: without a clear, the counter steps by exactly one.
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R5: a clear leaves the counter at zero.
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (rst)
    strobes.clearCount |=> cnt == '0);

  // R3: the captured byte holds between strobes.
  p_latch_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadLatch |=> $stable(latchQ));

  // R8: reset clears counter and captured byte.
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (cnt == '0) && (latchQ == '0));

endmodule

// File: rtl/playback_seq.sv
module playback_seq
  import playback_seq_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 8,
  parameter int CMD_BIT = 7,
  parameter int EOD_BIT = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memData,
  output logic              dataStrobe,
  output logic [DATA_W-1:0] latchData
);

  seqStrobes_t strobes;
  logic        phaseBit;

  playback_seq_ctrl #(
    .DATA_W (DATA_W),
    .CMD_BIT(CMD_BIT),
    .EOD_BIT(EOD_BIT)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .phaseBit(phaseBit),
    .latchQ  (latchData),
    .strobes (strobes)
  );

  playback_seq_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .memData (memData),
    .memAddr (memAddr),
    .phaseBit(phaseBit),
    .latchQ  (latchData)
  );

  assign dataStrobe = phaseBit;

endmodule

// File: tb/test_playback_seq.sv
module test_playback_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] memAddr;
  logic [7:0]  memData;
  logic        dataStrobe;
  logic [7:0]  latchData;

  logic [5:0]  nAddr;
  logic [7:0]  nData;
  logic        nStrobe;
  logic [7:0]  nLatch;

  int testsRun = 0;
  int testsFailed = 0;

  logic        plantAOn = 1'b0, plantBOn = 1'b0;
  logic [17:0] plantAAddr = '0, plantBAddr = '0;
  logic [7:0]  plantAVal = '0, plantBVal = '0;

  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [7:0] baseByte(input int a);
    return 8'((a * 37 + 11) & 8'h7F);
  endfunction

  function automatic logic [7:0] memModel(input logic [17:0] a);
    if (plantAOn && a == plantAAddr) return plantAVal;
    if (plantBOn && a == plantBAddr) return plantBVal;
    return baseByte(int'(a));
  endfunction

  always_comb memData = memModel(memAddr);
  always_comb nData   = baseByte(int'(nAddr));

  playback_seq i_playback_seq (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memData(memData),
    .dataStrobe(dataStrobe), .latchData(latchData)
  );

  playback_seq #(.ADDR_W(6)) i_playback_seq_narrow (
    .clk(clk), .rst(rst), .memAddr(nAddr), .memData(nData),
    .dataStrobe(nStrobe), .latchData(nLatch)
  );

  localparam int VEC_N = 7;
  localparam int vecEdges [VEC_N] = '{1, 2, 3, 8, 9, 100, 513};
  localparam int vecAddr  [VEC_N] = '{0, 1, 1, 4, 4, 50, 256};
  localparam bit vecStrb  [VEC_N] = '{1, 0, 1, 0, 1, 0, 1};

  task automatic check(input string req, input logic [17:0] expA,
                       input logic expS, input logic [7:0] expL);
    testsRun++;
    if (memAddr !== expA || dataStrobe !== expS || latchData !== expL) begin
      testsFailed++;
      $display("FAIL %s: addr=%0d strobe=%0b latch=%h expected addr=%0d strobe=%0b latch=%h",
               req, memAddr, dataStrobe, latchData, expA, expS, expL);
    end
  endtask

  task automatic edges(input int k);
    repeat (k) @(posedge clk);
    @(negedge clk);
  endtask

  // After return, the last rising edge had rst high; edge count starts at 0.
  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    // R8: reset state
    doReset();
    check("R8 reset state", 18'd0, 1'b0, 8'h00);

    // R1 R2 R3: marker-free counting, table walk
    begin
      int done = 0;
      for (int i = 0; i < VEC_N; i++) begin
        edges(vecEdges[i] - done);
        done = vecEdges[i];
        check("R1/R2/R3 counting vector", 18'(vecAddr[i]), vecStrb[i],
              (vecEdges[i] >= 2) ? memModel(18'(vecEdges[i] / 2 - 1)) : 8'h00);
      end
    end

    // R8: reset in mid-run clears everything
    doReset();
    check("R8 mid-run reset", 18'd0, 1'b0, 8'h00);

    // R4: 0x80 at address 3 and 0x04 at address 4 do not wrap
    plantAOn = 1'b1; plantAAddr = 18'd3; plantAVal = 8'h80;
    plantBOn = 1'b1; plantBAddr = 18'd4; plantBVal = 8'h04;
    doReset();
    edges(9);
    check("R4 command without end bit", 18'd4, 1'b1, 8'h80);
    edges(2);
    check("R4 end bit without command", 18'd5, 1'b1, 8'h04);

    // R4 R5: 0x8C at address 2 is a marker
    plantBOn = 1'b0;
    plantAAddr = 18'd2; plantAVal = 8'h8C;
    doReset();
    edges(6);
    check("R4 marker 0x8C captured", 18'd3, 1'b0, 8'h8C);
    edges(1);
    check("R4 marker 0x8C clears", 18'd0, 1'b0, 8'h8C);

    // R5 R6: 0x84 at address 5
    plantAAddr = 18'd5; plantAVal = 8'h84;
    doReset();
    edges(11);
    check("R6 live marker ignored", 18'd5, 1'b1, memModel(18'd4));
    edges(1);
    check("R5 marker captured", 18'd6, 1'b0, 8'h84);
    edges(1);
    check("R5 clear to zero", 18'd0, 1'b0, 8'h84);
    edges(1);
    check("R5 counting resumes", 18'd0, 1'b1, 8'h84);
    edges(1);
    check("R5 reload from address 0", 18'd1, 1'b0, memModel(18'd0));
    edges(10);
    check("R5 second pass captures marker", 18'd6, 1'b0, 8'h84);

    // R7: marker at address 0 never locks
    plantAAddr = 18'd0;
    doReset();
    edges(3);
    check("R7 clear after marker at 0", 18'd0, 1'b0, 8'h84);
    edges(1);
    check("R7 strobe still toggles", 18'd0, 1'b1, 8'h84);
    edges(2);
    check("R7 repeated single clear", 18'd0, 1'b0, 8'h84);
    plantAOn = 1'b0;

    // R9: narrow instance rolls over naturally
    doReset();
    edges(127);
    testsRun++;
    if (nAddr !== 6'd63 || nStrobe !== 1'b1) begin
      testsFailed++;
      $display("FAIL R9 top address: addr=%0d strobe=%0b expected addr=63 strobe=1",
               nAddr, nStrobe);
    end
    edges(1);
    testsRun++;
    if (nAddr !== 6'd0 || nStrobe !== 1'b0 || nLatch !== baseByte(63)) begin
      testsFailed++;
      $display("FAIL R9 rollover: addr=%0d strobe=%0b latch=%h expected addr=0 strobe=0 latch=%h",
               nAddr, nStrobe, nLatch, baseByte(63));
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule